// File: doc/BRIEF.md
# Little-Endian Load/Store Alignment Unit

This unit sits between a 32-bit data port and byte-addressable memory. Each request carries a byte address, an access size and, for stores, right-aligned write data. It also carries the raw 32-bit memory word for loads. The unit returns one registered result per 32-bit beat.

For a load, the result holds the addressed bytes moved down to bit 0. Byte and halfword loads are zero-extended or sign-extended, as the request asks. For a store, the result holds four byte-lane enables and the write data replicated onto the lanes those enables select. Byte 0 is always the least significant lane, at bits 7:0.

An access of S bytes at address A is legal only when A mod S is zero. A misaligned access produces one result with the error flag set and nothing else. A 64-bit access uses two consecutive 32-bit beats: the low word comes first, then the high word one word address later. The unit drops its ready for the single cycle of the second beat.

Top module: `lsa_unit`

## Requirements
- R1: While reset is low at a clock edge, and in the cycle after it, out_valid is 0 and in_ready is 1.
- R2: Size codes are 00 byte, 01 halfword, 10 word and 11 doubleword. out_misalign is 1 for a halfword with address bit 0 set, a word with address bits 1:0 non-zero, or a doubleword with address bits 2:0 non-zero. A byte access never raises it.
- R3: A misaligned access gives exactly one result. That result has out_be = 0000, out_wdata = 0 and out_rdata = 0, and no second beat follows, even for a doubleword.
- R4: A byte load returns lane addr[1:0] of in_rdata (bits 8k+7:8k for lane k) in bits 7:0. Bits 31:8 are copies of bit 7 when in_sext is 1, and zero otherwise.
- R5: A halfword load returns in_rdata[15:0] when addr[1] is 0, or in_rdata[31:16] when it is 1, in bits 15:0. Bits 31:16 are extended as in R4.
- R6: A word load returns in_rdata unchanged. in_sext has no effect on word or doubleword loads.
- R7: Store enables, where bit k enables lane k, are as follows. A byte store enables only bit addr[1:0]. A halfword store enables 0011 when addr[1] is 0 and 1100 when it is 1. Word and doubleword stores enable 1111. Every load result has out_be = 0000.
- R8: Store data is placed on the lanes as follows. A byte store repeats in_wdata[7:0] in all four lanes. A halfword store repeats in_wdata[15:0] in both halves. A word store passes in_wdata[31:0] unchanged.
- R9: An aligned doubleword produces beat 0, then beat 1 on the next cycle, with out_beat 0 then 1. out_word_addr is addr>>2 and then addr>>2 plus 1. Store data is in_wdata[31:0] on beat 0 and in_wdata[63:32] on beat 1. Load data is in_rdata from the accept cycle on beat 0 and in_rdata from the following cycle on beat 1. in_ready is 0 during that following cycle.
- R10: The result of a request accepted at a clock edge appears after that edge, with out_word_addr equal to addr>>2. out_valid is 0 after any edge at which no request was accepted and no second beat was due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_store | input | 1 | 1 store, 0 load |
| in_size | input | 2 | Access size code |
| in_sext | input | 1 | Sign-extend byte/halfword loads |
| in_addr | input | ADDR_W | Byte address |
| in_wdata | input | 64 | Right-aligned store data |
| in_rdata | input | 32 | Raw memory word for the current beat |
| out_valid | output | 1 | Result present |
| out_store | output | 1 | Result belongs to a store |
| out_beat | output | 1 | Beat index within a doubleword |
| out_word_addr | output | ADDR_W-2 | 32-bit word address of this beat |
| out_misalign | output | 1 | Access broke the alignment rule |
| out_be | output | 4 | Store byte-lane enables |
| out_wdata | output | 32 | Lane-placed store data |
| out_rdata | output | 32 | Aligned, extended load data |

## Verification
Two checks can meet in the same request: the alignment test and the doubleword beat sequencing. A doubleword at a word-aligned address that is not 8-aligned (offset 4) must produce only the error result. It must not hold ready low or emit a second beat. The bench sends such a request and then looks at the following cycle: out_valid must be 0 and in_ready must be 1. The bench then compares this with an aligned doubleword, whose second beat must carry the high word at the next word address.

// File: rtl/lsa_pkg.sv
// Package: shared lane geometry and the access-size encoding.
// Assumes a four-lane, byte-laned data port.
package lsa_pkg;
    localparam int LSA_LANE_W = 8;
    localparam int LSA_LANES  = 4;
    localparam int LSA_DATA_W = LSA_LANES * LSA_LANE_W;
    localparam int LSA_OFF_W  = $clog2(LSA_LANES);
    localparam int LSA_DW_W   = 2 * LSA_DATA_W;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_DWORD = 2'b11
    } lsa_size_e;
endpackage

// File: rtl/lsa_align_chk.sv
// Module: lsa_align_chk
// Applies the A mod S rule. S is a power of two, so the rule reduces to
// testing the low log2(S) address bits. Purely combinational.
module lsa_align_chk
    import lsa_pkg::*;
(
    input  lsa_size_e  size,
    input  logic [2:0] low_addr,
    output logic       misaligned
);
    logic [2:0] mask;

    // Build the mask of address bits that must be zero for this size.
    always_comb begin
        case (size)
            SZ_BYTE:  mask = 3'b000;
            SZ_HALF:  mask = 3'b001;
            SZ_WORD:  mask = 3'b011;
            default:  mask = 3'b111;
        endcase
    end

    assign misaligned = |(low_addr & mask);
endmodule

// File: rtl/lsa_load_fmt.sv
// Module: lsa_load_fmt
// Picks the addressed lanes of a raw little-endian memory word and moves
// them to bit 0, extending byte and halfword results. Word and doubleword
// beats pass straight through. Assumes four byte lanes.
module lsa_load_fmt
    import lsa_pkg::*;
(
    input  lsa_size_e              size,
    input  logic [LSA_OFF_W-1:0]   off,
    input  logic                   sext,
    input  logic [LSA_DATA_W-1:0]  rdata,
    output logic [LSA_DATA_W-1:0]  data
);
    localparam int HALF_W = 2 * LSA_LANE_W;

    logic [LSA_LANE_W-1:0] lane [LSA_LANES];
    logic [LSA_LANE_W-1:0] byte_v;
    logic [HALF_W-1:0]     half_v;

    genvar g;
    generate
        for (g = 0; g < LSA_LANES; g++) begin : g_lane
            assign lane[g] = rdata[g*LSA_LANE_W +: LSA_LANE_W];
        end
    endgenerate

    // Select the addressed byte and the addressed halfword.
    always_comb begin
        byte_v = lane[off];
        half_v = off[LSA_OFF_W-1] ? rdata[LSA_DATA_W-1 -: HALF_W]
                                  : rdata[HALF_W-1:0];
    end

    // Extend the selection to the full width according to size and sext.
    always_comb begin
        case (size)
            SZ_BYTE: data = {{(LSA_DATA_W-LSA_LANE_W){sext & byte_v[LSA_LANE_W-1]}}, byte_v};
            SZ_HALF: data = {{(LSA_DATA_W-HALF_W){sext & half_v[HALF_W-1]}}, half_v};
            default: data = rdata;
        endcase
    end
endmodule

// File: rtl/lsa_store_fmt.sv
// Module: lsa_store_fmt
// Computes per-lane write enables and lane-placed write data for one
// 32-bit beat. Byte and halfword data are replicated over the lanes, and
// the enables pick the live lanes. Assumes four byte lanes.
module lsa_store_fmt
    import lsa_pkg::*;
(
    input  lsa_size_e              size,
    input  logic [LSA_OFF_W-1:0]   off,
    input  logic [LSA_DATA_W-1:0]  wdata,
    output logic [LSA_LANES-1:0]   be,
    output logic [LSA_DATA_W-1:0]  lane_data
);
    genvar g;
    generate
        for (g = 0; g < LSA_LANES; g++) begin : g_lane
            localparam logic [LSA_OFF_W-1:0] LANE_ID = LSA_OFF_W'(g);
            localparam logic                 HALF_ID = 1'(g / 2);
            localparam int                   HALF_LO = (g % 2) * LSA_LANE_W;

            // Choose this lane's data byte and enable for the access size.
            always_comb begin
                case (size)
                    SZ_BYTE: begin
                        lane_data[g*LSA_LANE_W +: LSA_LANE_W] = wdata[LSA_LANE_W-1:0];
                        be[g] = (off == LANE_ID);
                    end
                    SZ_HALF: begin
                        lane_data[g*LSA_LANE_W +: LSA_LANE_W] = wdata[HALF_LO +: LSA_LANE_W];
                        be[g] = (off[LSA_OFF_W-1] == HALF_ID);
                    end
                    default: begin
                        lane_data[g*LSA_LANE_W +: LSA_LANE_W] = wdata[g*LSA_LANE_W +: LSA_LANE_W];
                        be[g] = 1'b1;
                    end
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lsa_unit.sv
// Module: lsa_unit (top)
// Alignment unit for loads and stores. Accepts one request per cycle and
// registers one result per 32-bit beat. An aligned doubleword takes a
// second beat on the next cycle, during which in_ready is low. Assumes
// the requester supplies the high memory word on in_rdata in that cycle.
// Misaligned accesses return only the error flag.
module lsa_unit
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic                   in_store,
    input  logic [1:0]             in_size,
    input  logic                   in_sext,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [LSA_DW_W-1:0]    in_wdata,
    input  logic [LSA_DATA_W-1:0]  in_rdata,
    output logic                   out_valid,
    output logic                   out_store,
    output logic                   out_beat,
    output logic [ADDR_W-3:0]      out_word_addr,
    output logic                   out_misalign,
    output logic [LSA_LANES-1:0]   out_be,
    output logic [LSA_DATA_W-1:0]  out_wdata,
    output logic [LSA_DATA_W-1:0]  out_rdata
);
    localparam int WA_W = ADDR_W - 2;

    logic                   busy_q;
    logic                   h_store;
    logic [WA_W-1:0]        h_waddr;
    logic [LSA_DATA_W-1:0]  h_wdata_hi;

    lsa_size_e              p_size;
    logic                   p_store;
    logic                   p_sext;
    logic [2:0]             p_low;
    logic [WA_W-1:0]        p_waddr;
    logic [LSA_DATA_W-1:0]  p_wdata;
    logic                   go;
    logic                   accept;
    logic                   mis;
    logic [LSA_DATA_W-1:0]  ld_data;
    logic [LSA_LANES-1:0]   st_be;
    logic [LSA_DATA_W-1:0]  st_data;

    assign in_ready = ~busy_q;
    assign accept   = in_valid & ~busy_q;
    assign go       = accept | busy_q;

    // Steer either the new request or the held second beat into the formatters.
    always_comb begin
        if (busy_q) begin
            p_size  = SZ_DWORD;
            p_store = h_store;
            p_sext  = 1'b0;
            p_low   = 3'b100;
            p_waddr = h_waddr;
            p_wdata = h_wdata_hi;
        end else begin
            p_size  = lsa_size_e'(in_size);
            p_store = in_store;
            p_sext  = in_sext;
            p_low   = in_addr[2:0];
            p_waddr = in_addr[ADDR_W-1:2];
            p_wdata = in_wdata[LSA_DATA_W-1:0];
        end
    end

    lsa_align_chk u_align (
        .size       (p_size),
        .low_addr   (busy_q ? 3'b000 : p_low),
        .misaligned (mis)
    );

    lsa_load_fmt u_load (
        .size  (p_size),
        .off   (p_low[LSA_OFF_W-1:0]),
        .sext  (p_sext),
        .rdata (in_rdata),
        .data  (ld_data)
    );

    lsa_store_fmt u_store (
        .size      (p_size),
        .off       (p_low[LSA_OFF_W-1:0]),
        .wdata     (p_wdata),
        .be        (st_be),
        .lane_data (st_data)
    );

    // Track the pending second beat of an aligned doubleword and hold its context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            h_store    <= 1'b0;
            h_waddr    <= '0;
            h_wdata_hi <= '0;
        end else if (busy_q) begin
            busy_q <= 1'b0;
        end else if (accept) begin
            busy_q     <= (p_size == SZ_DWORD) && !mis;
            h_store    <= in_store;
            h_waddr    <= in_addr[ADDR_W-1:2] + WA_W'(1);
            h_wdata_hi <= in_wdata[LSA_DW_W-1:LSA_DATA_W];
        end
    end

    // Register one result per beat, quieting data and enables on an error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_store     <= 1'b0;
            out_beat      <= 1'b0;
            out_word_addr <= '0;
            out_misalign  <= 1'b0;
            out_be        <= '0;
            out_wdata     <= '0;
            out_rdata     <= '0;
        end else begin
            out_valid <= go;
            if (go) begin
                out_store     <= p_store;
                out_beat      <= busy_q;
                out_word_addr <= p_waddr;
                out_misalign  <= mis;
                out_be        <= (p_store && !mis) ? st_be : '0;
                out_wdata     <= (p_store && !mis) ? st_data : '0;
                out_rdata     <= (!p_store && !mis) ? ld_data : '0;
            end
        end
    end

    a_r3_error_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_misalign) |-> (out_be == '0 && out_wdata == '0 && out_rdata == '0));

    a_r3_no_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_misalign) |-> !busy_q);

    a_r9_second_beat_follows: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> (out_valid && out_beat));

    a_r9_word_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_beat) |-> (out_word_addr == $past(out_word_addr) + WA_W'(1)));

    a_r7_store_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_store && !out_misalign) |->
            ($countones(out_be) == 1 || $countones(out_be) == 2 || $countones(out_be) == 4));

    a_r7_load_no_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_store) |-> (out_be == '0));

    a_r10_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !busy_q) |=> !out_valid);
endmodule

// File: tb/lsa_unit_tb.sv
// Directed bench for lsa_unit: one task per scenario, each checking its own results.
module lsa_unit_tb;
    localparam int ADDR_W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_store = 1'b0;
    logic [1:0]  in_size = 2'b00;
    logic        in_sext = 1'b0;
    logic [31:0] in_addr = '0;
    logic [63:0] in_wdata = '0;
    logic [31:0] in_rdata = '0;
    logic        out_valid, out_store, out_beat, out_misalign;
    logic [29:0] out_word_addr;
    logic [3:0]  out_be;
    logic [31:0] out_wdata, out_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lsa_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_store(in_store), .in_size(in_size), .in_sext(in_sext),
        .in_addr(in_addr), .in_wdata(in_wdata), .in_rdata(in_rdata),
        .out_valid(out_valid), .out_store(out_store), .out_beat(out_beat),
        .out_word_addr(out_word_addr), .out_misalign(out_misalign),
        .out_be(out_be), .out_wdata(out_wdata), .out_rdata(out_rdata)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Present one request for one cycle, then leave the result visible.
    task automatic issue(input logic st, input logic [1:0] sz, input logic sx,
                         input logic [31:0] a, input logic [63:0] wd, input logic [31:0] rd);
        @(negedge clk);
        in_valid = 1'b1; in_store = st; in_size = sz; in_sext = sx;
        in_addr = a; in_wdata = wd; in_rdata = rd;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 in_ready in reset", in_ready, 1);
        @(negedge clk); rst_n = 1'b1;
        check("R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic t_load_byte;
        logic [31:0] w = 32'h80F1_7F12;
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 2; s++) begin
                logic [7:0] b = w[8*k +: 8];
                logic [31:0] e = (s == 1) ? {{24{b[7]}}, b} : {24'h0, b};
                issue(1'b0, 2'b00, s[0], 32'h100 + k, '0, w);
                check("R4 byte load data", out_rdata, e);
                check("R2 byte never misaligned", out_misalign, 0);
                check("R7 load enables zero", out_be, 0);
                check("R10 word address", out_word_addr, 32'h100 >> 2);
            end
        end
    endtask

    task automatic t_load_half;
        logic [31:0] w = 32'h9ABC_1234;
        issue(1'b0, 2'b01, 1'b1, 32'h22, '0, w);
        check("R5 upper half signed", out_rdata, 32'hFFFF_9ABC);
        issue(1'b0, 2'b01, 1'b0, 32'h22, '0, w);
        check("R5 upper half unsigned", out_rdata, 32'h0000_9ABC);
        issue(1'b0, 2'b01, 1'b1, 32'h20, '0, w);
        check("R5 lower half signed positive", out_rdata, 32'h0000_1234);
    endtask

    task automatic t_load_word;
        issue(1'b0, 2'b10, 1'b1, 32'h44, '0, 32'hDEAD_BEEF);
        check("R6 word ignores sext", out_rdata, 32'hDEAD_BEEF);
        check("R6 word aligned", out_misalign, 0);
    endtask

    task automatic t_store;
        for (int k = 0; k < 4; k++) begin
            issue(1'b1, 2'b00, 1'b0, 32'h10 + k, 64'hA5, '0);
            check("R7 byte enable", out_be, 4'b0001 << k);
            check("R8 byte replicated", out_wdata, 32'hA5A5_A5A5);
        end
        issue(1'b1, 2'b01, 1'b0, 32'h12, 64'hBEEF, '0);
        check("R7 upper half enables", out_be, 4'b1100);
        check("R8 half replicated", out_wdata, 32'hBEEF_BEEF);
        issue(1'b1, 2'b01, 1'b0, 32'h10, 64'h1234, '0);
        check("R7 lower half enables", out_be, 4'b0011);
        issue(1'b1, 2'b10, 1'b0, 32'h18, 64'h1122_3344_5566_7788, '0);
        check("R7 word enables", out_be, 4'b1111);
        check("R8 word data", out_wdata, 32'h5566_7788);
        check("R10 store flag", out_store, 1);
    endtask

    task automatic t_misalign;
        issue(1'b1, 2'b01, 1'b0, 32'h31, 64'hFFFF, '0);
        check("R2 odd halfword flagged", out_misalign, 1);
        check("R3 no enables on error", out_be, 0);
        check("R3 no data on error", out_wdata, 0);
        issue(1'b0, 2'b10, 1'b0, 32'h36, '0, 32'hFFFF_FFFF);
        check("R2 word at offset 6 flagged", out_misalign, 1);
        check("R3 no load data on error", out_rdata, 0);
        issue(1'b0, 2'b10, 1'b0, 32'h34, '0, 32'h1);
        check("R2 word at offset 4 aligned", out_misalign, 0);
        issue(1'b1, 2'b11, 1'b0, 32'h44, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        check("R2 doubleword at offset 4 flagged", out_misalign, 1);
        check("R3 ready stays high", in_ready, 1);
        @(negedge clk);
        check("R3 no second beat", out_valid, 0);
    endtask

    task automatic t_dword_store;
        issue(1'b1, 2'b11, 1'b0, 32'h208, 64'hCAFE_0001_BEEF_0002, '0);
        check("R9 beat 0 index", out_beat, 0);
        check("R9 beat 0 low word", out_wdata, 32'hBEEF_0002);
        check("R9 beat 0 enables", out_be, 4'b1111);
        check("R9 beat 0 address", out_word_addr, 32'h208 >> 2);
        check("R9 ready low in second cycle", in_ready, 0);
        @(negedge clk);
        check("R9 beat 1 valid", out_valid, 1);
        check("R9 beat 1 index", out_beat, 1);
        check("R9 beat 1 high word", out_wdata, 32'hCAFE_0001);
        check("R9 beat 1 address", out_word_addr, (32'h208 >> 2) + 1);
        check("R9 ready back", in_ready, 1);
        @(negedge clk);
        check("R10 idle after doubleword", out_valid, 0);
    endtask

    task automatic t_dword_load;
        @(negedge clk);
        in_valid = 1'b1; in_store = 1'b0; in_size = 2'b11; in_sext = 1'b1;
        in_addr = 32'h310; in_rdata = 32'h8765_4321;
        @(negedge clk);
        in_valid = 1'b0; in_rdata = 32'hF00D_CAFE;
        check("R9 load beat 0 low word", out_rdata, 32'h8765_4321);
        check("R9 load beat 0 store flag", out_store, 0);
        @(negedge clk);
        check("R9 load beat 1 high word", out_rdata, 32'hF00D_CAFE);
        check("R9 load beat 1 index", out_beat, 1);
        check("R7 doubleword load enables", out_be, 0);
    endtask

    initial begin
        t_reset();
        t_load_byte();
        t_load_half();
        t_load_word();
        t_store();
        t_misalign();
        t_dword_store();
        t_dword_load();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule